// File: doc/BRIEF.md
# PLL Holdover Charge-Pump Controller

This block decides when a PLL charge pump is placed in high impedance (holdover) and when it is allowed to drive again. Two sources can request holdover. In manual mode, a falling edge on an active-low external sync input starts it. In automatic mode, loss of the lock indication starts it and holds the VCO near its last frequency. Leaving holdover is never immediate. Once the cause has cleared, the pump resumes only on the next reference-path PFD event. On that same event the block pulses a synchronous reset to the feedback B counter, so the divider edges line up again. The prescaler is not reset.

The block also tells each output channel divider whether to shut its output off while sync is low. Any divider whose ignore bit is set keeps running. The sync input and the lock flag come from outside the clock domain, so each passes through a two-flop synchronizer before use. The PFD event is taken to be a one-cycle pulse that is already synchronous to `clk`.

Top module: `holdover_cp_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after reset, `cp_tristate` is 0, `bcnt_reset` is 0 and `ch_off` is all zeros.
- R2: With `man_en` high, a high-to-low change of `sync_n` sets `cp_tristate` to 1 on the third rising clock edge after the change. A `sync_n` that is already low when `man_en` is raised does not start holdover, because only the edge counts.
- R3: Holdover ends only at a clock edge where `ref_pfd_evt` is 1 and every active cause has cleared. For manual holdover, clearing means the synchronized `sync_n` is high. A PFD event that arrives while `sync_n` is still low is ignored. With no PFD event, `cp_tristate` stays 1 indefinitely.
- R4: `bcnt_reset` is a one-cycle pulse. It is high exactly in the first cycle where `cp_tristate` has returned to 0, which is the cycle after the releasing PFD edge.
- R5: Bit i of `ch_off` is 1 when the synchronized `sync_n` is low and bit i of `ignore_sync` is 0. It follows `sync_n` with a latency of three rising edges, whatever the mode enables are.
- R6: With `auto_en` high, a low synchronized `lock_in` sets `cp_tristate` on the third edge after `lock_in` falls. Automatic holdover ends on a PFD event that arrives while the synchronized lock is high.
- R7: When both modes are enabled, `cp_tristate` is the OR of the two holdover conditions. A PFD event that clears only one of them leaves `cp_tristate` at 1 and produces no `bcnt_reset`.
- R8: With both enables low, neither a sync falling edge nor a loss of lock raises `cp_tristate`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sync_n | input | 1 | Asynchronous active-low sync/holdover request |
| lock_in | input | 1 | Asynchronous lock-detect flag, 1 means locked |
| ref_pfd_evt | input | 1 | One-cycle pulse marking a reference-path PFD rising edge |
| man_en | input | 1 | Enables manual holdover |
| auto_en | input | 1 | Enables automatic holdover |
| ignore_sync | input | NUM_CH | Per-channel flag: 1 keeps that divider running while sync is low |
| cp_tristate | output | 1 | 1 places the charge pump in high impedance |
| bcnt_reset | output | 1 | One-cycle synchronous reset for the feedback B counter |
| ch_off | output | NUM_CH | Per-channel request to turn the divider output off |

## Verification
Each asynchronous input takes two synchronizer stages and then one register, so `cp_tristate` and `ch_off` respond to a change of `sync_n` or `lock_in` on the third rising edge. `cp_tristate` and `bcnt_reset` respond to a PFD pulse on the first edge that samples it. The bench drives all inputs on the falling edge. It then waits three rising edges before checking a level change and one rising edge before checking a release. It also checks one edge early to confirm the entry is not premature, and one edge late to confirm the B-counter pulse has ended.

// File: rtl/holdover_pkg.sv
// Package: shared types and constants for the holdover charge-pump controller.
// Assumes: nothing beyond IEEE 1800-2017 synthesizable constructs.
package holdover_pkg;

    // Index of each holdover source inside the cause vector
    localparam int unsigned SRC_MAN  = 0;
    localparam int unsigned SRC_AUTO = 1;
    localparam int unsigned NUM_SRC  = 2;

    typedef logic [NUM_SRC-1:0] cause_vec_t;

    // True when the update from cur to nxt removes the last active cause
    function automatic logic last_cause_cleared(input cause_vec_t cur, input cause_vec_t nxt);
        return (|cur) && !(|nxt);
    endfunction

endpackage

// File: rtl/holdover_sync.sv
// Module: multi-stage flop synchronizer for slow asynchronous control levels.
// Assumes: inputs are quasi-static levels; each bit is synchronized on its own.
module holdover_sync #(
    parameter int unsigned WIDTH   = 1,
    parameter int unsigned STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);
    logic [WIDTH-1:0] chain_q [STAGES];

    // Shift the asynchronous level through the flop chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < int'(STAGES); i++) chain_q[i] <= RST_VAL;
        end else begin
            chain_q[0] <= d_async;
            for (int i = 1; i < int'(STAGES); i++) chain_q[i] <= chain_q[i-1];
        end
    end

    assign q_sync = chain_q[STAGES-1];
endmodule

// File: rtl/holdover_cause.sv
// Module: tracks one holdover cause. A cause is entered when `enter` is high
// and is released only on a PFD pulse while its release condition holds.
// Assumes: `pfd` is a one-cycle pulse synchronous to clk.
module holdover_cause (
    input  logic clk,
    input  logic rst_n,
    input  logic enter,
    input  logic release_ok,
    input  logic pfd,
    output logic hold_q,
    output logic hold_d
);
    // Next-state: a held cause persists until a qualified PFD event
    always_comb begin
        if (hold_q) hold_d = !(pfd && release_ok);
        else        hold_d = enter;
    end

    // Register the cause state
    always_ff @(posedge clk) begin
        if (!rst_n) hold_q <= 1'b0;
        else        hold_q <= hold_d;
    end
endmodule

// File: rtl/holdover_chan_gate.sv
// Module: per-channel output shut-off request for one channel divider.
// Assumes: sync_low is already synchronized to clk.
module holdover_chan_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_low,
    input  logic ignore,
    output logic off_q
);
    // Request shut-off while sync is low unless the channel ignores sync
    always_ff @(posedge clk) begin
        if (!rst_n) off_q <= 1'b0;
        else        off_q <= sync_low && !ignore;
    end
endmodule

// File: rtl/holdover_cp_ctrl.sv
// Module: top of the holdover controller. Combines the manual (sync edge)
// and automatic (loss of lock) holdover causes, drives the charge-pump
// tri-state and the B-counter reset, and gates the channel dividers.
// Assumes: ref_pfd_evt is a clk-synchronous one-cycle pulse; sync_n and
// lock_in are asynchronous. Mode enables gate only entry, not release.
module holdover_cp_ctrl #(
    parameter int unsigned NUM_CH      = 4,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sync_n,
    input  logic              lock_in,
    input  logic              ref_pfd_evt,
    input  logic              man_en,
    input  logic              auto_en,
    input  logic [NUM_CH-1:0] ignore_sync,
    output logic              cp_tristate,
    output logic              bcnt_reset,
    output logic [NUM_CH-1:0] ch_off
);
    import holdover_pkg::*;

    localparam logic [1:0] SYNC_IDLE = 2'b11;

    logic [1:0]  raw_in, synced;
    logic        sync_s, lock_s, sync_prev_q, sync_fall;
    cause_vec_t  enter_v, relok_v, hold_q_v, hold_d_v;
    logic        bres_q;

    assign raw_in = {lock_in, sync_n};

    holdover_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_IDLE)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_async(raw_in), .q_sync(synced)
    );
    assign sync_s = synced[0];
    assign lock_s = synced[1];

    // Remember the previous synchronized sync level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) sync_prev_q <= 1'b1;
        else        sync_prev_q <= sync_s;
    end
    assign sync_fall = sync_prev_q && !sync_s;

    // Entry and release conditions for each cause
    always_comb begin
        enter_v           = '0;
        relok_v           = '0;
        enter_v[SRC_MAN]  = man_en && sync_fall;
        relok_v[SRC_MAN]  = sync_s;
        enter_v[SRC_AUTO] = auto_en && !lock_s;
        relok_v[SRC_AUTO] = lock_s;
    end

    for (genvar s = 0; s < int'(NUM_SRC); s++) begin : g_cause
        holdover_cause u_cause (
            .clk(clk), .rst_n(rst_n), .enter(enter_v[s]), .release_ok(relok_v[s]),
            .pfd(ref_pfd_evt), .hold_q(hold_q_v[s]), .hold_d(hold_d_v[s])
        );
    end

    // Pulse the B-counter reset on the edge that clears the last cause
    always_ff @(posedge clk) begin
        if (!rst_n) bres_q <= 1'b0;
        else        bres_q <= last_cause_cleared(hold_q_v, hold_d_v);
    end

    for (genvar c = 0; c < int'(NUM_CH); c++) begin : g_chan
        holdover_chan_gate u_gate (
            .clk(clk), .rst_n(rst_n), .sync_low(!sync_s),
            .ignore(ignore_sync[c]), .off_q(ch_off[c])
        );
    end

    assign cp_tristate = |hold_q_v;
    assign bcnt_reset  = bres_q;
endmodule

// File: rtl/holdover_cp_ctrl_chk.sv
// Module: assertion checker for holdover_cp_ctrl, attached with bind.
// Assumes: observes top-level ports only.
module holdover_cp_ctrl_chk #(
    parameter int unsigned NUM_CH = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ref_pfd_evt,
    input logic              man_en,
    input logic              auto_en,
    input logic [NUM_CH-1:0] ignore_sync,
    input logic              cp_tristate,
    input logic              bcnt_reset,
    input logic [NUM_CH-1:0] ch_off
);
    AST_BRES_AT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        bcnt_reset |-> ($past(cp_tristate) && !cp_tristate)); // R4
    AST_BRES_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        bcnt_reset |=> !bcnt_reset); // R4
    AST_RELEASE_ON_PFD: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cp_tristate) |-> $past(ref_pfd_evt)); // R3
    AST_ENTRY_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cp_tristate) |-> $past(man_en || auto_en)); // R8
    AST_IGNORED_CHAN_ON: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((ch_off & $past(ignore_sync)) == '0)); // R5
endmodule

bind holdover_cp_ctrl holdover_cp_ctrl_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk(clk), .rst_n(rst_n), .ref_pfd_evt(ref_pfd_evt), .man_en(man_en),
    .auto_en(auto_en), .ignore_sync(ignore_sync), .cp_tristate(cp_tristate),
    .bcnt_reset(bcnt_reset), .ch_off(ch_off)
);

// File: tb/holdover_cp_ctrl_test.sv
module holdover_cp_ctrl_test;
    localparam int NCH = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sync_n = 1'b1, lock_in = 1'b1, ref_pfd_evt = 1'b0;
    logic man_en = 1'b0, auto_en = 1'b0;
    logic [NCH-1:0] ignore_sync = '0;
    logic cp_tristate, bcnt_reset;
    logic [NCH-1:0] ch_off;
    int errors = 0, checks = 0;

    always #5 clk = ~clk;

    holdover_cp_ctrl #(.NUM_CH(NCH)) uut (
        .clk(clk), .rst_n(rst_n), .sync_n(sync_n), .lock_in(lock_in),
        .ref_pfd_evt(ref_pfd_evt), .man_en(man_en), .auto_en(auto_en),
        .ignore_sync(ignore_sync), .cp_tristate(cp_tristate),
        .bcnt_reset(bcnt_reset), .ch_off(ch_off)
    );

    // Vector: {man,auto,sync_n,lock,pfd, ign[3:0], exp_tri, exp_bres, exp_off[3:0]}
    localparam int NV = 15;
    localparam logic [14:0] VEC [NV] = '{
        {5'b10110, 4'b0000, 2'b00, 4'b0000}, // R1 idle driving
        {5'b10010, 4'b0000, 2'b10, 4'b1111}, // R2 R5 sync falls
        {5'b10011, 4'b0000, 2'b10, 4'b1111}, // R3 pfd while low ignored
        {5'b10110, 4'b0000, 2'b10, 4'b0000}, // R3 sync high, no pfd yet
        {5'b10111, 4'b0000, 2'b01, 4'b0000}, // R3 R4 release
        {5'b10010, 4'b1010, 2'b10, 4'b0101}, // R5 ignore mask
        {5'b10111, 4'b1010, 2'b01, 4'b0000}, // R4 release
        {5'b01100, 4'b1010, 2'b10, 4'b0000}, // R6 loss of lock
        {5'b01101, 4'b1010, 2'b10, 4'b0000}, // R6 pfd while unlocked
        {5'b01111, 4'b1010, 2'b01, 4'b0000}, // R6 relock release
        {5'b11000, 4'b1010, 2'b10, 4'b0101}, // R7 both causes
        {5'b11101, 4'b1010, 2'b10, 4'b0000}, // R7 only manual cleared
        {5'b11111, 4'b1010, 2'b01, 4'b0000}, // R7 last cleared
        {5'b00000, 4'b1010, 2'b00, 4'b0101}, // R8 disabled
        {5'b00110, 4'b1010, 2'b00, 4'b0000}  // R8 back idle
    };

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        tick(2);
        check("R1 tri in reset", {7'd0, cp_tristate}, 8'd0);
        check("R1 bres in reset", {7'd0, bcnt_reset}, 8'd0);
        check("R1 ch_off in reset", {4'd0, ch_off}, 8'd0);
        rst_n = 1'b1;
        tick(1);
        check("R1 tri after reset", {7'd0, cp_tristate}, 8'd0);

        for (int v = 0; v < NV; v++) begin
            man_en = VEC[v][14]; auto_en = VEC[v][13]; sync_n = VEC[v][12];
            lock_in = VEC[v][11]; ignore_sync = VEC[v][9:6];
            tick(3);
            if (VEC[v][10]) begin
                ref_pfd_evt = 1'b1;
                tick(1);
                ref_pfd_evt = 1'b0;
            end
            check($sformatf("vec%0d tri R2 R3 R6 R7 R8", v), {7'd0, cp_tristate}, {7'd0, VEC[v][5]});
            check($sformatf("vec%0d bres R4 R7", v), {7'd0, bcnt_reset}, {7'd0, VEC[v][4]});
            check($sformatf("vec%0d ch_off R5", v), {4'd0, ch_off}, {4'd0, VEC[v][3:0]});
            if (VEC[v][4]) begin
                tick(1);
                check("R4 bres single cycle", {7'd0, bcnt_reset}, 8'd0);
            end
        end

        // R2 entry latency: not yet after two edges, set on the third
        ignore_sync = '0; man_en = 1'b1; auto_en = 1'b0; sync_n = 1'b0;
        tick(2);
        check("R2 not yet at edge 2", {7'd0, cp_tristate}, 8'd0);
        tick(1);
        check("R2 set at edge 3", {7'd0, cp_tristate}, 8'd1);
        // R3 stays in holdover with no PFD
        sync_n = 1'b1;
        tick(60);
        check("R3 held without pfd", {7'd0, cp_tristate}, 8'd1);
        ref_pfd_evt = 1'b1; tick(1); ref_pfd_evt = 1'b0;
        check("R3 release", {7'd0, cp_tristate}, 8'd0);

        // R2 level without edge: enable raised while sync already low
        man_en = 1'b0; sync_n = 1'b0;
        tick(4);
        man_en = 1'b1;
        tick(4);
        check("R2 level low no entry", {7'd0, cp_tristate}, 8'd0);
        sync_n = 1'b1;
        tick(4);
        check("R2 still driving", {7'd0, cp_tristate}, 8'd0);
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end
endmodule